// File: doc/BRIEF.md
# Aging Guardband Adaptation Controller

This controller closes the loop between in-flop aging sensors and the clock and supply settings of a logic domain. The sensors flag a path whose data settles inside the timing guardband, which predicts a failure before any real error appears. The controller counts coarse epoch ticks to form a long evaluation interval. It gathers the combined sensor flag during a monitoring window at the start of each interval. At the end of the interval it makes a single decision: leave the settings alone, slow the clock one divider step, or raise the supply code one step.

Reset starts the domain with a small guardband, given by the default divider and supply codes. A runtime mode input sets which of the two settings is used first. When that setting runs out, the other one is used. The supply code never goes above a programmed ceiling. When both settings are at their limits and a violation is still reported, a sticky alarm is raised. After every decision the controller pulses a clear to the sensors and starts a new interval. The sensors are enabled only inside the monitoring window, so they age as little as possible.

Top module: `guardband_adapt_ctrl`

## Requirements
- R1: After reset, div_code equals DIV_INIT, volt_code equals VOLT_INIT, alarm and sensor_clr are 0, and monitor_en is 1 exactly when mon_window is nonzero.
- R2: Ticks are counted from 0 within an interval. The interval ends on the tick that brings the count to interval_len (a value of 0 acts as 1). div_code, volt_code and alarm change only on the clock edge that ends an interval.
- R3: With fast_first = 0 (frequency first), a violating interval increments div_code by one while div_code < DIV_MAX. A higher div_code means a slower clock.
- R4: With fast_first = 1 (voltage first), a violating interval increments volt_code by one while volt_code < vmax_code. volt_code is never raised above vmax_code.
- R5: When the preferred setting is at its limit (div_code = DIV_MAX, or volt_code >= vmax_code), a violating interval steps the other setting instead.
- R6: When both settings are at their limits and an interval violates, alarm goes to 1 and stays at 1 until reset.
- R7: sensor_clr is 1 for exactly the one cycle after each interval end. The tick count then restarts at 0 and the record of violations is emptied.
- R8: An interval with no recorded violation leaves div_code, volt_code and alarm unchanged.
- R9: monitor_en is 1 while the tick count within the interval is below mon_window. A viol_any seen while monitor_en is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| epoch_tick | input | 1 | One-cycle epoch pulse |
| viol_any | input | 1 | OR of all sensor sticky flags |
| interval_len | input | EPOCH_W | Epochs per evaluation interval |
| mon_window | input | EPOCH_W | Epochs at interval start with monitoring enabled |
| vmax_code | input | VOLT_W | Highest supply code allowed |
| fast_first | input | 1 | 0: frequency first, 1: voltage first |
| div_code | output | DIV_W | Clock divider code |
| volt_code | output | VOLT_W | Supply voltage code |
| monitor_en | output | 1 | Sensor enable |
| sensor_clr | output | 1 | One-cycle clear to the sensors |
| alarm | output | 1 | Sticky flag: no correction left |

## Verification
The bench builds the block with DIV_W=2, DIV_MAX=3, VOLT_W=3, VOLT_INIT=1, EPOCH_W=4 and SYNC_STAGES=0. The divider then runs out after three steps, and the supply after at most three steps for the ceilings swept (0 to 4). This brings fallback and the sticky alarm within reach after a few intervals. The sweep covers both modes, interval lengths 1 to 3, a full or empty monitoring window, and a ceiling below the reset supply code. It compares every tick against an arithmetic model kept in the bench.

// File: rtl/gbc_pkg.sv
package gbc_pkg;
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_DIV   = 2'd1,
      ACT_VOLT  = 2'd2,
      ACT_ALARM = 2'd3
   } gbc_act_e;
endpackage

// File: rtl/gbc_interval_timer.sv
module gbc_interval_timer #(
   parameter int EPOCH_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               epoch_tick,
   input  logic [EPOCH_W-1:0] interval_len,
   input  logic [EPOCH_W-1:0] mon_window,
   output logic               end_o,
   output logic               mon_en_o
);
   localparam int CW = EPOCH_W + 1;

   logic [EPOCH_W-1:0] ep_cnt;
   logic [CW-1:0]      next_cnt;

   assign next_cnt = {1'b0, ep_cnt} + CW'(1);
   assign end_o    = epoch_tick && (next_cnt >= {1'b0, interval_len});
   assign mon_en_o = (ep_cnt < mon_window);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ep_cnt <= '0;
      else if (end_o)      ep_cnt <= '0;
      else if (epoch_tick) ep_cnt <= next_cnt[EPOCH_W-1:0];
   end

   // R2: the count never reaches interval_len without an interval end
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (interval_len > 1 && $past(interval_len) == interval_len) |-> (ep_cnt < interval_len));
endmodule

// File: rtl/gbc_viol_collect.sv
module gbc_viol_collect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic viol_in,
   input  logic mon_en,
   input  logic end_i,
   output logic viol_now_o,
   output logic seen_o
);
   logic viol_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign viol_q = viol_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2+1-1:0], viol_in};
         end
         assign viol_q = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign viol_now_o = seen_o | (viol_q & mon_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     seen_o <= 1'b0;
      else if (end_i) seen_o <= 1'b0;
      else            seen_o <= viol_now_o;
   end

   // R9: with monitoring off, the record cannot become set
   p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(mon_en) && !$past(seen_o)) |-> !seen_o);
endmodule

// File: rtl/gbc_knob_policy.sv
module gbc_knob_policy
   import gbc_pkg::*;
#(
   parameter int DIV_W     = 3,
   parameter int DIV_MAX   = 7,
   parameter int DIV_INIT  = 0,
   parameter int VOLT_W    = 4,
   parameter int VOLT_INIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              end_i,
   input  logic              viol_i,
   input  logic              fast_first,
   input  logic [VOLT_W-1:0] vmax_code,
   output logic [DIV_W-1:0]  div_o,
   output logic [VOLT_W-1:0] volt_o,
   output logic              alarm_o,
   output logic              clr_o
);
   localparam logic [DIV_W-1:0]  DMAX  = DIV_W'(DIV_MAX);
   localparam logic [DIV_W-1:0]  DINIT = DIV_W'(DIV_INIT);
   localparam logic [VOLT_W-1:0] VINIT = VOLT_W'(VOLT_INIT);

   logic     div_room, volt_room;
   gbc_act_e act;

   assign div_room  = (div_o < DMAX);
   assign volt_room = (volt_o < vmax_code);

   always_comb begin
      act = ACT_NONE;
      if (viol_i) begin
         if (!fast_first) begin
            if (div_room)       act = ACT_DIV;
            else if (volt_room) act = ACT_VOLT;
            else                act = ACT_ALARM;
         end else begin
            if (volt_room)      act = ACT_VOLT;
            else if (div_room)  act = ACT_DIV;
            else                act = ACT_ALARM;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_o   <= DINIT;
         volt_o  <= VINIT;
         alarm_o <= 1'b0;
         clr_o   <= 1'b0;
      end else begin
         clr_o <= end_i;
         if (end_i) begin
            case (act)
               ACT_DIV:   div_o   <= div_o + DIV_W'(1);
               ACT_VOLT:  volt_o  <= volt_o + VOLT_W'(1);
               ACT_ALARM: alarm_o <= 1'b1;
               default:   ;
            endcase
         end
      end
   end

   p_div_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (div_o != $past(div_o)) |-> (div_o == $past(div_o) + DIV_W'(1) && div_o <= DMAX));
   p_volt_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (volt_o != $past(volt_o)) |-> (volt_o == $past(volt_o) + VOLT_W'(1) && volt_o <= $past(vmax_code)));
   p_alarm_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_o |=> alarm_o);
endmodule

// File: rtl/guardband_adapt_ctrl.sv
module guardband_adapt_ctrl #(
   parameter int DIV_W       = 3,
   parameter int DIV_MAX     = 7,
   parameter int DIV_INIT    = 0,
   parameter int VOLT_W      = 4,
   parameter int VOLT_INIT   = 0,
   parameter int EPOCH_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               epoch_tick,
   input  logic               viol_any,
   input  logic [EPOCH_W-1:0] interval_len,
   input  logic [EPOCH_W-1:0] mon_window,
   input  logic [VOLT_W-1:0]  vmax_code,
   input  logic               fast_first,
   output logic [DIV_W-1:0]   div_code,
   output logic [VOLT_W-1:0]  volt_code,
   output logic               monitor_en,
   output logic               sensor_clr,
   output logic               alarm
);
   if (DIV_MAX >= (1 << DIV_W) || DIV_INIT > DIV_MAX) begin : g_bad_div
      $error("guardband_adapt_ctrl: divider limits do not fit DIV_W");
   end
   if (VOLT_INIT >= (1 << VOLT_W)) begin : g_bad_volt
      $error("guardband_adapt_ctrl: VOLT_INIT does not fit VOLT_W");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3 || EPOCH_W < 2) begin : g_bad_misc
      $error("guardband_adapt_ctrl: SYNC_STAGES or EPOCH_W out of range");
   end

   logic end_w, viol_now, seen_w;

   gbc_interval_timer #(.EPOCH_W(EPOCH_W)) timer_i (
      .clk(clk), .rst_n(rst_n), .epoch_tick(epoch_tick),
      .interval_len(interval_len), .mon_window(mon_window),
      .end_o(end_w), .mon_en_o(monitor_en));

   gbc_viol_collect #(.SYNC_STAGES(SYNC_STAGES)) coll_i (
      .clk(clk), .rst_n(rst_n), .viol_in(viol_any), .mon_en(monitor_en),
      .end_i(end_w), .viol_now_o(viol_now), .seen_o(seen_w));

   gbc_knob_policy #(
      .DIV_W(DIV_W), .DIV_MAX(DIV_MAX), .DIV_INIT(DIV_INIT),
      .VOLT_W(VOLT_W), .VOLT_INIT(VOLT_INIT)) pol_i (
      .clk(clk), .rst_n(rst_n), .end_i(end_w), .viol_i(viol_now),
      .fast_first(fast_first), .vmax_code(vmax_code),
      .div_o(div_code), .volt_o(volt_code), .alarm_o(alarm), .clr_o(sensor_clr));

   p_change_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (div_code != $past(div_code) || volt_code != $past(volt_code) || $rose(alarm)) |-> sensor_clr);
   p_clr_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sensor_clr |-> !seen_w);
   p_clr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sensor_clr && interval_len > 1) |=> !sensor_clr);
endmodule

// File: tb/guardband_adapt_ctrl_tb_top.sv
module guardband_adapt_ctrl_tb_top;
   localparam int DW = 2, DMAX = 3, DINIT = 0, VW = 3, VINIT = 1, EW = 4;

   logic clk = 1'b0, rst_n = 1'b0, epoch_tick = 1'b0, viol_any = 1'b0, fast_first = 1'b0;
   logic [EW-1:0] interval_len = 4'd1, mon_window = 4'd1;
   logic [VW-1:0] vmax_code = '0;
   logic [DW-1:0] div_code;
   logic [VW-1:0] volt_code;
   logic monitor_en, sensor_clr, alarm;

   int total = 0, bad = 0;
   int m_cnt, m_seen, m_div, m_volt, m_alarm;
   bit done = 0;

   always #5 clk = ~clk;

   guardband_adapt_ctrl #(.DIV_W(DW), .DIV_MAX(DMAX), .DIV_INIT(DINIT), .VOLT_W(VW),
      .VOLT_INIT(VINIT), .EPOCH_W(EW), .SYNC_STAGES(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .epoch_tick(epoch_tick), .viol_any(viol_any),
      .interval_len(interval_len), .mon_window(mon_window), .vmax_code(vmax_code),
      .fast_first(fast_first), .div_code(div_code), .volt_code(volt_code),
      .monitor_en(monitor_en), .sensor_clr(sensor_clr), .alarm(alarm));

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_state(input string req);
      chk({req, " div"}, int'(div_code), m_div);
      chk({req, " volt"}, int'(volt_code), m_volt);
      chk({req, " alarm"}, int'(alarm), m_alarm);
      chk({req, " monitor_en"}, int'(monitor_en), int'(m_cnt < int'(mon_window)));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m_cnt = 0; m_seen = 0; m_div = DINIT; m_volt = VINIT; m_alarm = 0;
      chk("R1 clr", int'(sensor_clr), 0);
      chk_state("R1");
   endtask

   task automatic step(input bit v);
      int  mon, seen_now, len, fin;
      mon = int'(m_cnt < int'(mon_window));
      seen_now = m_seen | (int'(v) & mon);
      len = (interval_len == 0) ? 1 : int'(interval_len);
      fin = int'(m_cnt + 1 >= len);
      viol_any = v; epoch_tick = 1'b1;
      @(negedge clk);
      viol_any = 1'b0; epoch_tick = 1'b0;
      if (fin != 0) begin
         if (seen_now != 0) begin
            int droom, vroom;
            droom = int'(m_div < DMAX);
            vroom = int'(m_volt < int'(vmax_code));
            if (!fast_first) begin
               if (droom != 0) m_div++;          // R3
               else if (vroom != 0) m_volt++;    // R5
               else m_alarm = 1;                 // R6
            end else begin
               if (vroom != 0) m_volt++;         // R4
               else if (droom != 0) m_div++;     // R5
               else m_alarm = 1;                 // R6
            end
         end
         m_cnt = 0; m_seen = 0;
         chk("R7 clr pulse", int'(sensor_clr), 1);
         chk_state(seen_now != 0 ? "R3/R4/R5/R6 decision" : "R8 clean interval");
      end else begin
         m_cnt++; m_seen = seen_now;
         chk("R2 no clr mid-interval", int'(sensor_clr), 0);
         chk_state(v ? "R2 R9 mid-interval" : "R2 mid-interval");
      end
      @(negedge clk);
      chk("R7 clr one cycle", int'(sensor_clr), 0);
      chk_state("R2 idle");
   endtask

   initial begin
      for (int md = 0; md < 2; md++)
         for (int vm = 0; vm < 5; vm++)
            for (int ln = 1; ln < 4; ln++)
               for (int wf = 0; wf < 2; wf++) begin
                  fast_first   = md[0];
                  vmax_code    = VW'(vm);
                  interval_len = EW'(ln);
                  mon_window   = (wf == 0) ? EW'(ln) : EW'(0);
                  do_reset();
                  for (int k = 0; k < 24; k++)
                     step(((k * 7 + vm + ln) % 5) != 0);
                  if (wf == 1) begin
                     chk("R9 gated flags ignored div", int'(div_code), DINIT);
                     chk("R9 gated flags ignored volt", int'(volt_code), VINIT);
                  end
               end
      // interval_len 0 acts as 1
      interval_len = '0; mon_window = 4'd1; fast_first = 1'b0; vmax_code = 3'd2;
      do_reset();
      for (int k = 0; k < 8; k++) step(k[0]);
      done = 1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule